// File: doc/BRIEF.md
# Guarded Clock-Multiplier Configuration Registers

This register block holds the settings of an on-chip clock multiplier and keeps them from changing by accident. Software writes a control word, holding the enable and connect bits, through a single-cycle write port. It also writes a configuration word, holding the multiplier and the post-divider code, through the same port. Both words land in pending registers. The multiplier does not see them until software writes the unlock pair 0xAA and then 0x55 to the feed register on back-to-back write cycles. That pair copies every pending field into the active outputs at once.

The block returns the active settings and the multiplier's lock input in a status word. A power-down input clears the active enable and connect bits. They stay cleared after wake-up until software repeats the full program-and-unlock sequence.

Top module: `pll_guard`

## Requirements
- R1: After the asynchronous reset, all pending and active fields are zero: the multiplier is disabled and disconnected, the multiplier code and divider code are 0, and every readable register reads 0.
- R2: A write to register select 0 (control, data bits 1:0) or register select 1 (configuration, data bits 6:0) updates only the pending copy. Reads at those selects return the pending value, and the active outputs do not change.
- R3: A write of 0xAA to register select 2 (feed), followed on the very next cycle by a write of 0x55 to select 2, copies all pending fields to the active outputs at the clock edge of the second write.
- R4: A broken unlock sequence leaves the active values unchanged. A sequence is broken by an idle cycle between the two words, by a second word other than 0x55, or by a write to another register between them.
- R5: In the configuration word, bits 4:0 carry M−1 (M from 1 to 32) and bits 6:5 carry the divider code (0,1,2,3 selecting P=1,2,4,8). Configuration 0x24 therefore gives multiplier code 4 (M=5) and divider code 1 (P=2).
- R6: Control bit 0 is enable and bit 1 is connect. The enable output equals the active enable bit.
- R7: The connect output is high only when the active enable bit, the active connect bit and the lock input are all high.
- R8: Register select 3 (status) reads the active multiplier code in bits 4:0, the divider code in bits 6:5, the active enable in bit 8, the active connect bit in bit 9 and the lock input in bit 10 (mask 0x0400).
- R9: While power-down is high, the active enable and connect bits are cleared from the next edge on, an unlock sequence has no effect, and the bits remain cleared after power-down falls until a new complete unlock sequence.
- R10: A write of 0xAA that arrives while the block waits for 0x55 restarts the sequence, so a 0x55 on the following cycle completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 2 | Register select for the read |
| rd_data_o | output | DW | Read data, combinational |
| lock_i | input | 1 | Lock indication from the multiplier |
| pd_i | input | 1 | Power-down request |
| pll_en_o | output | 1 | Active enable |
| pll_conn_o | output | 1 | Connect, gated by lock |
| mult_code_o | output | 5 | Active M−1 |
| div_code_o | output | 2 | Active post-divider code |

## Verification
Two things can fall in the same cycle: the 0x55 word that completes an unlock, and a power-down request. The bench arms the sequence with 0xAA, then raises power-down in the cycle it writes 0x55. Power-down must win. The active bits stay cleared and must not come back once power-down falls, and only a fresh unlock sequence with power-down low restores them. A behavioural reference model is compared with every output on every clock, so the outcome is also judged against the edges around the collision.

// File: rtl/pll_guard_pkg.sv
package pll_guard_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_FEED = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd3;
  localparam int MC_W  = 5;
  localparam int DC_W  = 2;
  localparam int CFG_W = MC_W + DC_W;
  localparam int ST_EN   = 8;
  localparam int ST_CONN = 9;
  localparam int ST_LOCK = 10;

  typedef struct packed {
    logic conn;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [DC_W-1:0] dc;
    logic [MC_W-1:0] mc;
  } cfg_t;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq #(
  parameter int DW = 32,
  parameter logic [DW-1:0] KEY_A = 'hAA,
  parameter logic [DW-1:0] KEY_B = 'h55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          feed_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pd_i,
  output logic          commit_o
);
  logic armed_q;
  logic key_a_wr, key_b_wr;

  assign key_a_wr = wr_en_i && feed_sel_i && (wr_data_i == KEY_A);
  assign key_b_wr = wr_en_i && feed_sel_i && (wr_data_i == KEY_B);
  assign commit_o = armed_q && key_b_wr && !pd_i;

  // armed for exactly one cycle after a first key; anything else drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (pd_i) armed_q <= 1'b0;
    else           armed_q <= key_a_wr;
  end

  assert_rearm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_a_wr && !pd_i) |=> armed_q);
  assert_break_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> !commit_o);
endmodule

// File: rtl/pll_stat_mux.sv
module pll_stat_mux
  import pll_guard_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [SEL_W-1:0] rd_sel_i,
  input  ctrl_t            pend_ctrl_i,
  input  cfg_t             pend_cfg_i,
  input  ctrl_t            act_ctrl_i,
  input  cfg_t             act_cfg_i,
  input  logic             lock_i,
  output logic [DW-1:0]    rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      SEL_CTRL: rd_data_o[1:0]       = {pend_ctrl_i.conn, pend_ctrl_i.en};
      SEL_CFG:  rd_data_o[CFG_W-1:0] = pend_cfg_i;
      SEL_STAT: begin
        rd_data_o[CFG_W-1:0] = act_cfg_i;
        rd_data_o[ST_EN]     = act_ctrl_i.en;
        rd_data_o[ST_CONN]   = act_ctrl_i.conn;
        rd_data_o[ST_LOCK]   = lock_i;
      end
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pll_guard.sv
module pll_guard
  import pll_guard_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             lock_i,
  input  logic             pd_i,
  output logic             pll_en_o,
  output logic             pll_conn_o,
  output logic [MC_W-1:0]  mult_code_o,
  output logic [DC_W-1:0]  div_code_o
);
  ctrl_t pend_ctrl_q, act_ctrl_q;
  cfg_t  pend_cfg_q,  act_cfg_q;
  logic  commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ctrl_q <= '0;
      pend_cfg_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_CTRL) pend_ctrl_q <= ctrl_t'(wr_data_i[1:0]);
      if (wr_sel_i == SEL_CFG)  pend_cfg_q  <= cfg_t'(wr_data_i[CFG_W-1:0]);
    end
  end

  pll_feed_seq #(.DW(DW)) i_feed (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .feed_sel_i (wr_sel_i == SEL_FEED),
    .wr_data_i  (wr_data_i),
    .pd_i       (pd_i),
    .commit_o   (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_ctrl_q <= '0;
      act_cfg_q  <= '0;
    end else if (pd_i) begin
      act_ctrl_q <= '0;  // divider settings are kept, clock is shut off
    end else if (commit) begin
      act_ctrl_q <= pend_ctrl_q;
      act_cfg_q  <= pend_cfg_q;
    end
  end

  assign pll_en_o    = act_ctrl_q.en;
  assign pll_conn_o  = act_ctrl_q.en && act_ctrl_q.conn && lock_i;
  assign mult_code_o = act_cfg_q.mc;
  assign div_code_o  = act_cfg_q.dc;

  pll_stat_mux #(.DW(DW)) i_stat (
    .rd_sel_i    (rd_sel_i),
    .pend_ctrl_i (pend_ctrl_q),
    .pend_cfg_i  (pend_cfg_q),
    .act_ctrl_i  (act_ctrl_q),
    .act_cfg_i   (act_cfg_q),
    .lock_i      (lock_i),
    .rd_data_o   (rd_data_o)
  );

  assert_pd_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!pll_en_o && !pll_conn_o));
  assert_conn_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_conn_o |-> (lock_i && pll_en_o));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(mult_code_o) && $stable(div_code_o)));
  assert_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (mult_code_o == $past(pend_cfg_q.mc) && div_code_o == $past(pend_cfg_q.dc)));
endmodule

// File: tb/test_pll_guard.sv
module test_pll_guard;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, lock = 1'b0, pd = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = 2'd3;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic en_o, conn_o;
  logic [4:0] mc_o;
  logic [1:0] dc_o;
  int n_run = 0, n_fail = 0;

  // reference model state
  int m_pc = 0, m_pf = 0, m_ac = 0, m_af = 0;
  bit m_armed = 0;

  always #10 clk = ~clk;

  pll_guard #(.DW(DW)) i_pll_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .lock_i(lock), .pd_i(pd), .pll_en_o(en_o), .pll_conn_o(conn_o),
    .mult_code_o(mc_o), .div_code_o(dc_o));

  always @(posedge clk) begin
    if (rst_n) begin
      bit nxt_arm;
      nxt_arm = 0;
      if (wr_en && wr_sel == 0) m_pc <= int'(wr_data[1:0]);
      if (wr_en && wr_sel == 1) m_pf <= int'(wr_data[6:0]);
      if (pd) begin
        m_ac <= 0;
      end else if (wr_en && wr_sel == 2) begin
        if (m_armed && wr_data == 32'h55) begin m_ac <= m_pc; m_af <= m_pf; end
        nxt_arm = (wr_data == 32'hAA);
      end
      m_armed <= pd ? 1'b0 : nxt_arm;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(int sel);
    case (sel)
      0: return m_pc;
      1: return m_pf;
      3: return m_af | ((m_ac & 1) << 8) | (((m_ac >> 1) & 1) << 9) | (int'(lock) << 10);
      default: return 0;
    endcase
  endfunction

  task automatic model_cmp();
    chk("model pll_en", en_o, m_ac & 1);
    chk("model pll_conn", conn_o, (m_ac == 3) && lock);
    chk("model mult", mc_o, m_af & 31);
    chk("model div", dc_o, m_af >> 5);
    chk("model rd_data", rd_data, exp_rd(int'(rd_sel)));
  endtask

  task automatic tick(input bit we, input int sel, input int d);
    wr_en = we; wr_sel = 2'(sel); wr_data = DW'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    model_cmp();
  endtask

  task automatic feed();
    tick(1, 2, 'hAA); tick(1, 2, 'h55);
  endtask

  initial begin
    #30_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #5; #40; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", rd_data, 0); chk("R1 en", en_o, 0); chk("R1 mult", mc_o, 0);
    model_cmp();
    tick(1, 1, 'h24); tick(1, 0, 'h01);
    rd_sel = 1; #1 chk("R2 pending cfg readback", rd_data, 'h24);
    rd_sel = 0; #1 chk("R2 pending ctrl readback", rd_data, 1);
    chk("R2 active unchanged", mc_o, 0);
    rd_sel = 3;
    feed();
    chk("R3 enable after feed", en_o, 1);
    chk("R5 mult code 0x24", mc_o, 4); chk("R5 div code 0x24", dc_o, 1);
    chk("R6 enable bit", en_o, 1);
    #1 chk("R8 status", rd_data, 'h124);
    lock = 1; #1 chk("R8 lock bit", rd_data, 'h524);
    chk("R7 no connect with ctrl 0x01", conn_o, 0);
    tick(1, 0, 'h03); feed();
    chk("R7 connect", conn_o, 1);
    lock = 0; #1 chk("R7 connect drops w/o lock", conn_o, 0);
    lock = 1;
    tick(1, 1, 'h1F);
    tick(1, 2, 'hAA); tick(0, 0, 0); tick(1, 2, 'h55);
    chk("R4 idle gap", mc_o, 4);
    tick(1, 2, 'hAA); tick(1, 2, 'h56);
    chk("R4 wrong word", mc_o, 4);
    tick(1, 2, 'hAA); tick(1, 0, 'h03); tick(1, 2, 'h55);
    chk("R4 other write", mc_o, 4);
    tick(1, 2, 'hAA); tick(1, 2, 'hAA); tick(1, 2, 'h55);
    chk("R10 restart", mc_o, 31);
    pd = 1; tick(0, 0, 0);
    chk("R9 pd enable off", en_o, 0); chk("R9 pd connect off", conn_o, 0);
    pd = 0; tick(0, 0, 0); tick(0, 0, 0);
    chk("R9 stays off after wake", en_o, 0);
    tick(1, 2, 'hAA); pd = 1; tick(1, 2, 'h55); pd = 0;
    chk("R9 feed during pd ignored", en_o, 0);
    tick(0, 0, 0);
    chk("R9 still off", en_o, 0);
    feed();
    chk("R9 restored by feed", en_o, 1); chk("R9 connect restored", conn_o, 1);
    for (int i = 0; i < 40; i++) begin
      pd = (i % 11 == 5);
      rd_sel = 2'(i % 4);
      tick(1, i % 3, (i % 5 == 0) ? 'hAA : ((i % 5 == 1) ? 'h55 : i * 7));
    end
    pd = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule